// File: doc/BRIEF.md
# Watertight Tessellation Coordinate Generator

This block turns a single launch request, made of an integer subdivision factor and a primitive kind (segment or quad), into a stream of parametric sample points. It produces one point per clock while the consumer is ready. For a segment it walks one parametric axis. For a quad it walks both axes, row by row.

Each point is folded about the middle of its axis. A sample in the upper half is reported as its distance from the far end. The point also carries a corner-order code that tells the consumer which corner the folded coordinates are measured from. Two neighbouring primitives that share an edge therefore compute every edge sample from the same end, with the same arithmetic, and the surface stays crack-free. The downstream evaluator uses the order code to restore the original corners and to unfold the coordinates.

Coordinates are unsigned 16-bit fractions in which 0x8000 means one half. The sample with index k on an axis is derived from an exact quotient-and-remainder stepper, so rounding error does not build up along the walk.

Top module: `tess_coord_gen`

## Requirements
- R1: During and right after reset, `out_valid` and `done` are both 0.
- R2: A factor input of 0 is used as 1, and a factor input above 64 is used as 64. The stream length follows the adjusted factor `f`.
- R3: With `quad_in`=0 the block emits f+1 points with axis index k = 0..f in increasing order. `out_v` is 0. `out_u` equals floor(m*65536/f), where m = k when 2k <= f and m = f-k otherwise.
- R4: The order code packs four 2-bit corner indices: bits [1:0] hold the first, [3:2] the second, [5:4] the third and [7:6] the fourth. The unfolded order (0,1,2,3) is 8'hE4. The order folded in u is (1,0,3,2), coded 8'hB1.
- R5: A sample exactly on the midpoint (2k = f) counts as unfolded. It carries `out_u` (or `out_v`) = 0x8000 and the unfolded order for that axis.
- R6: With `quad_in`=1 the block emits (f+1)^2 points, v index in the outer loop and u index in the inner loop. Each axis value follows the rule of R3. The order code is 8'hE4 when neither axis is folded, 8'hB1 when only u is folded, 8'h1B (3,2,1,0) when only v is folded, and 8'h4E (2,3,0,1) when both are folded.
- R7: Every emitted coordinate is at most 0x8000.
- R8: While `out_valid`=1 and `out_ready`=0, the next cycle keeps `out_valid` high and keeps `out_u`, `out_v` and `out_order` unchanged.
- R9: In the cycle after the last accepted point, `done` is 1 for exactly one cycle and `out_valid` is 0.
- R10: `start`, `factor_in` and `quad_in` are ignored while a stream or its done pulse is in progress. The running stream continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request, taken only when idle |
| factor_in | input | 7 | Subdivision factor, clamped to 1..64 |
| quad_in | input | 1 | 1 = quad domain, 0 = segment domain |
| out_ready | input | 1 | Consumer accepts the current point |
| out_valid | output | 1 | A point is presented |
| out_u | output | 16 | Folded u coordinate, 0x8000 = one half |
| out_v | output | 16 | Folded v coordinate, 0x8000 = one half |
| out_order | output | 8 | Corner-order code, four 2-bit indices |
| done | output | 1 | One-cycle pulse after the last point |

## Verification
Segment streams with odd factors (1, 5) have no midpoint sample, while even factors (6, 64) do. Comparing the two shows whether the fold boundary is placed at 2k > f or shifted by one. Quad streams of sizes 1, 2, 3, 4, 7 and 64 cover all four order codes, and the row-major walk separates a swapped loop order from a correct one. Factors 0 and 100 probe the clamp at both ends. A periodic back-pressure pattern, together with a start pulse and a changed factor in the middle of a stream, checks that stalls and late requests leave the sequence unchanged.

// File: rtl/tess_pkg.sv
package tess_pkg;
  localparam int TESS_FW   = 16;  // fraction bits of a coordinate
  localparam int TESS_KW   = 7;   // bits of factor and axis index
  localparam int TESS_FMAX = 64;  // largest accepted factor

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} tess_state_e;

  // Corner i of the output list is corner (i xor mask) of the patch.
  // u fold swaps along x (mask 1), v fold swaps along y (mask 3).
  function automatic logic [7:0] order_code(input logic fu, input logic fv);
    logic [1:0] mask;
    logic [7:0] code;
    mask = {fv, fu ^ fv};
    for (int i = 0; i < 4; i++) code[2*i +: 2] = 2'(i) ^ mask;
    return code;
  endfunction

  function automatic logic [TESS_KW-1:0] clamp_factor(input logic [TESS_KW-1:0] f);
    if (f == '0) return TESS_KW'(1);
    if (f > TESS_KW'(TESS_FMAX)) return TESS_KW'(TESS_FMAX);
    return f;
  endfunction

  // Whole and fractional part of one axis step, 2^FW / f.
  function automatic logic [TESS_FW:0] step_whole(input logic [TESS_KW-1:0] f);
    logic [TESS_FW:0] one;
    one = {1'b1, {TESS_FW{1'b0}}};
    return one / {{(TESS_FW+1-TESS_KW){1'b0}}, f};
  endfunction

  function automatic logic [TESS_KW-1:0] step_rem(input logic [TESS_KW-1:0] f);
    logic [TESS_FW:0] one;
    logic [TESS_FW:0] rem;
    one = {1'b1, {TESS_FW{1'b0}}};
    rem = one % {{(TESS_FW+1-TESS_KW){1'b0}}, f};
    return rem[TESS_KW-1:0];
  endfunction
endpackage

// File: rtl/tess_axis.sv
module tess_axis
  import tess_pkg::*;
#(
  parameter int FW = TESS_FW,
  parameter int KW = TESS_KW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic [KW-1:0] factor,
  input  logic [FW:0]   inc_q,
  input  logic [KW-1:0] inc_r,
  output logic          last,
  output logic          fold,
  output logic [FW-1:0] coord
);
  localparam logic [FW:0] ONE = {1'b1, {FW{1'b0}}};

  logic [KW-1:0] k;
  logic [FW:0]   q;      // floor(k * 2^FW / factor)
  logic [KW-1:0] r;      // remainder of that quotient
  logic [KW:0]   rsum;
  logic          wrap;
  logic [FW:0]   mirror; // floor((factor-k) * 2^FW / factor)

  assign rsum   = {1'b0, r} + {1'b0, inc_r};
  assign wrap   = rsum >= {1'b0, factor};
  assign last   = (k == factor);
  assign fold   = {k, 1'b0} > {1'b0, factor};
  assign mirror = ONE - q - {{FW{1'b0}}, |r};
  assign coord  = fold ? mirror[FW-1:0] : q[FW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k <= '0;
      q <= '0;
      r <= '0;
    end else if (clear) begin
      k <= '0;
      q <= '0;
      r <= '0;
    end else if (step) begin
      k <= k + KW'(1);
      q <= q + inc_q + {{FW{1'b0}}, wrap};
      r <= wrap ? KW'(rsum - {1'b0, factor}) : rsum[KW-1:0];
    end
  end

  // R7: a folded value never reaches one half or beyond
  assert_fold_below_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fold |-> (!mirror[FW] && mirror[FW-1:0] < ONE[FW:1]));

  // R3: the index never runs past the factor
  assert_index_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (k <= factor) || $past(clear));

  // R3: the remainder stays below the divisor
  assert_rem_below_factor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    r < factor);
endmodule

// File: rtl/tess_ctrl.sv
module tess_ctrl
  import tess_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic quad,
  input  logic out_ready,
  input  logic u_last,
  input  logic v_last,
  output logic launch,
  output logic out_valid,
  output logic done,
  output logic clr_u,
  output logic stp_u,
  output logic clr_v,
  output logic stp_v
);
  tess_state_e st, st_nx;
  logic fire, row_end, final_pt;

  assign launch    = (st == ST_IDLE) && start;
  assign out_valid = (st == ST_RUN);
  assign done      = (st == ST_DONE);
  assign fire      = out_valid && out_ready;
  assign row_end   = fire && u_last;
  assign final_pt  = row_end && (!quad || v_last);

  assign stp_u = fire && !u_last;
  assign clr_u = launch || (row_end && !final_pt);
  assign clr_v = launch;
  assign stp_v = row_end && !final_pt;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (start)    st_nx = ST_RUN;
      ST_RUN:  if (final_pt) st_nx = ST_DONE;
      ST_DONE:               st_nx = ST_IDLE;
      default:               st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  // R9: done lasts one cycle
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: the last accepted point is followed by done
  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    final_pt |=> done && !out_valid);

  // R8: a stalled point stays presented
  assert_hold_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
endmodule

// File: rtl/tess_coord_gen.sv
module tess_coord_gen
  import tess_pkg::*;
#(
  parameter int FW = TESS_FW,
  parameter int KW = TESS_KW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [KW-1:0] factor_in,
  input  logic          quad_in,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [FW-1:0] out_u,
  output logic [FW-1:0] out_v,
  output logic [7:0]    out_order,
  output logic          done
);
  localparam logic [FW:0] ONE = {1'b1, {FW{1'b0}}};

  logic [KW-1:0] fac_r;
  logic          quad_r;
  logic [FW:0]   inc_q;
  logic [KW-1:0] inc_r;
  logic          launch;
  logic          clr_u, stp_u, clr_v, stp_v;
  logic          u_last, v_last, u_fold, v_fold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fac_r  <= KW'(1);
      quad_r <= 1'b0;
    end else if (launch) begin
      fac_r  <= clamp_factor(factor_in);
      quad_r <= quad_in;
    end
  end

  assign inc_q = step_whole(fac_r);
  assign inc_r = step_rem(fac_r);

  tess_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .quad(quad_r),
    .out_ready(out_ready), .u_last(u_last), .v_last(v_last),
    .launch(launch), .out_valid(out_valid), .done(done),
    .clr_u(clr_u), .stp_u(stp_u), .clr_v(clr_v), .stp_v(stp_v)
  );

  tess_axis #(.FW(FW), .KW(KW)) u_axis_u (
    .clk(clk), .rst_n(rst_n), .clear(clr_u), .step(stp_u),
    .factor(fac_r), .inc_q(inc_q), .inc_r(inc_r),
    .last(u_last), .fold(u_fold), .coord(out_u)
  );

  tess_axis #(.FW(FW), .KW(KW)) u_axis_v (
    .clk(clk), .rst_n(rst_n), .clear(clr_v), .step(stp_v),
    .factor(fac_r), .inc_q(inc_q), .inc_r(inc_r),
    .last(v_last), .fold(v_fold), .coord(out_v)
  );

  assign out_order = order_code(u_fold, v_fold);

  // R1: nothing presented straight out of reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !done);

  // R7: emitted coordinates stay within one half
  assert_coord_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_u <= ONE[FW:1]) && (out_v <= ONE[FW:1]));

  // R8: stalled point keeps its payload
  assert_stall_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_u) && $stable(out_v) && $stable(out_order));

  // R3: segments keep v at zero
  assert_segment_v_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !quad_r) |-> out_v == '0);

  // R6: only the four legal corner orders appear
  assert_order_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_order == 8'hE4 || out_order == 8'hB1 ||
                   out_order == 8'h1B || out_order == 8'h4E));

  // R10: configuration frozen while streaming
  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> $stable(fac_r) && $stable(quad_r));

  // R9: done never overlaps a presented point
  assert_done_no_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);
endmodule

// File: tb/tess_coord_gen_bench.sv
module tess_coord_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  factor_in = '0;
  logic        quad_in = 1'b0;
  logic        out_ready = 1'b0;
  logic        out_valid, done;
  logic [15:0] out_u, out_v;
  logic [7:0]  out_order;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  tess_coord_gen u_tess_coord_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .factor_in(factor_in),
    .quad_in(quad_in), .out_ready(out_ready), .out_valid(out_valid),
    .out_u(out_u), .out_v(out_v), .out_order(out_order), .done(done)
  );

  // {factor[6:0], quad, stall, poke}
  localparam logic [9:0] VEC [12] = '{
    {7'd6,   1'b0, 1'b0, 1'b0},
    {7'd1,   1'b0, 1'b0, 1'b0},
    {7'd0,   1'b0, 1'b0, 1'b0},
    {7'd5,   1'b0, 1'b1, 1'b0},
    {7'd7,   1'b1, 1'b0, 1'b0},
    {7'd4,   1'b1, 1'b1, 1'b1},
    {7'd64,  1'b0, 1'b0, 1'b0},
    {7'd2,   1'b1, 1'b0, 1'b0},
    {7'd3,   1'b1, 1'b0, 1'b1},
    {7'd100, 1'b0, 1'b0, 1'b0},
    {7'd1,   1'b1, 1'b0, 1'b0},
    {7'd64,  1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_coord(input int f, input int k);
    int m;
    m = (2 * k > f) ? (f - k) : k;
    return (m * 65536) / f;
  endfunction

  function automatic int exp_order(input bit fu, input bit fv);
    if (!fu && !fv) return 'hE4;
    if (fu && !fv)  return 'hB1;
    if (!fu && fv)  return 'h1B;
    return 'h4E;
  endfunction

  task automatic run_case(input int fin, input bit q, input bit stall, input bit poke);
    int nf, total, idx, cyc, ku, kv;
    bit held;
    logic [15:0] hu, hv;
    logic [7:0]  ho;
    string rq;
    nf = (fin == 0) ? 1 : ((fin > 64) ? 64 : fin);
    total = q ? (nf + 1) * (nf + 1) : nf + 1;
    rq = q ? "R6" : "R3";
    idx = 0; cyc = 0; held = 0;
    @(negedge clk);
    start = 1'b1; factor_in = 7'(fin); quad_in = q; out_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (idx < total && cyc < 20000) begin
      if (held) begin
        chk(out_valid && out_u == hu && out_v == hv && out_order == ho,
            "R8", "payload held under stall", int'(out_u), int'(hu));
        held = 0;
      end
      start = poke && idx == 2;                       // R10 late request
      factor_in = poke ? 7'd3 : 7'(fin);
      quad_in = poke ? ~q : q;
      out_ready = stall ? (cyc % 3 != 1) : 1'b1;
      if (!out_valid || done) begin
        chk(0, rq, "point missing", int'(out_valid), 1);
      end else if (out_ready) begin
        ku = idx % (nf + 1);
        kv = q ? idx / (nf + 1) : 0;
        chk(int'(out_u) == exp_coord(nf, ku), rq, "u", int'(out_u), exp_coord(nf, ku));
        chk(int'(out_v) == (q ? exp_coord(nf, kv) : 0), rq, "v",
            int'(out_v), q ? exp_coord(nf, kv) : 0);
        chk(int'(out_order) == exp_order(2*ku > nf, q && 2*kv > nf),
            q ? "R6" : "R4", "order", int'(out_order),
            exp_order(2*ku > nf, q && 2*kv > nf));
        if (2 * ku == nf) chk(out_u == 16'h8000, "R5", "midpoint u", int'(out_u), 32768);
        chk(out_u <= 16'h8000 && out_v <= 16'h8000, "R7", "range", int'(out_u), 32768);
        idx++;
      end else begin
        held = 1; hu = out_u; hv = out_v; ho = out_order;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(idx == total, (fin == 0 || fin > 64) ? "R2" : rq, "point count", idx, total);
    chk(done && !out_valid, "R9", "done after last point", int'(done), 1);
    @(negedge clk);
    chk(!done && !out_valid, "R9", "done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !done, "R1", "idle in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !done, "R1", "idle after reset", int'(out_valid), 0);

    for (int i = 0; i < 12; i++)
      run_case(int'(VEC[i][9:3]), VEC[i][2], VEC[i][1], VEC[i][0]);

    // R1: reset in the middle of a stream
    @(negedge clk);
    start = 1'b1; factor_in = 7'd9; quad_in = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!out_valid && !done, "R1", "reset aborts stream", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !done, "R1", "quiet after abort", int'(out_valid), 0);

    // R3: a fresh segment stream after the abort starts at k = 0
    run_case(6, 1'b0, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule